// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block holds the digital half of an 8-bit successive-approximation analog-to-digital converter. It derives a conversion tick from the system clock, drives the sample/hold switches and a channel-select code for an external analog multiplexer, and presents a trial code to an external DAC whose comparator answers with one bit per step. Software sees two byte-wide registers. A control/status register carries the enable, the channel number and a completion flag. A data register holds the most recent result.

Once enabled, the sequencer runs by itself. A sample-load phase charges the hold capacitor from the selected input. A conversion phase then isolates the capacitor and resolves the code one bit per tick, starting at the most significant bit. The result is written to the data register and the flag is raised, and the next load phase starts at once. Clearing the enable stops the sequencer and returns it to idle.

Register map: address 0 is the control/status register, address 1 is the data register. Reads are combinational on `reg_rdata`. `reg_wr_en` and `reg_rd_en` are one-cycle strobes sampled on the rising clock edge.

Top module: `sar_adc_seq`

## Requirements
- R1: The conversion tick fires once every 4 system clocks while enabled. The conversion phase lasts exactly 8 ticks, so `sh_hold` stays high for exactly 32 clocks per conversion.
- R2: The control/status register reads as {flag at bit 7, 0 at bit 6, enable at bit 5, 0 at bit 4, channel at bits 3:0}. Writes store bit 5 and bits 3:0 and ignore the other bits. `ch_sel` always shows the stored channel.
- R3: During the load phase, `sh_load` is high for 4 ticks (16 clocks) and `sh_hold` is low. During the conversion phase, `sh_hold` is high and `sh_load` is low. The two lines are never high together. A change of the analog input while `sh_hold` is high does not alter the result.
- R4: Bits are resolved MSB first. The first trial code of a conversion is 0x80. At each tick the trial bit is kept when `cmp_above` is 1 (input at or above the DAC level) and cleared otherwise, and the next lower bit is set. The result is the largest code that does not exceed the sampled input.
- R5: An input at or above the top reference converts to 0xFF. An input at or below the bottom reference converts to 0x00. No other indication is given.
- R6: While the enable bit is 1, a new load phase starts on the same edge that stores a result, with no register access needed.
- R7: The completion flag is set on the edge that stores a result. It is cleared by a read strobe to the data register or by a write strobe to the control/status register. When a clear and a new result fall on the same edge, the flag ends up set.
- R8: Writing the enable bit as 0 aborts any conversion. From the second clock edge after the write strobe, both `sh_load` and `sh_hold` are low and stay low. The data register keeps its last value.
- R9: After reset, both registers read 0x00, `sh_load`, `sh_hold` and `ch_sel` are 0, and `dac_code` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (has side effects only on the data register) |
| reg_addr | input | 1 | 0 = control/status, 1 = data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ch_sel | output | 4 | Analog multiplexer channel select |
| sh_load | output | 1 | High: sample capacitor connected to the input |
| sh_hold | output | 1 | High: capacitor isolated, conversion in progress |
| dac_code | output | 8 | Trial code for the external DAC |
| cmp_above | input | 1 | Comparator: 1 when the held input is at or above the DAC level |

## Verification
Two actions can land on the same clock edge: the completion flag being set by a finished conversion, and the flag being cleared by a data-register read. The bench watches for the rising edge of `sh_hold` and counts exactly 31 further clocks. It then issues the data read in the cycle just before the final step, so the read strobe and the result store share one edge. The flag is judged one cycle later: it must still be 1, and `sh_hold` must have fallen exactly then. A second read must then return the freshly stored code.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_CONV = 2'd2
  } sar_state_t;

  localparam logic ADDR_CSR  = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  localparam int CSR_FLAG_BIT = 7;
  localparam int CSR_EN_BIT   = 5;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // two ticks are never adjacent when the division ratio exceeds one
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int RES_W      = 8,
  parameter int LOAD_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             cmp_above,
  output logic             sh_load,
  output logic             sh_hold,
  output logic [RES_W-1:0] dac_code,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int LCW = (LOAD_TICKS > 1) ? $clog2(LOAD_TICKS) : 1;
  localparam int BIW = (RES_W > 1) ? $clog2(RES_W) : 1;

  sar_state_t       state_q;
  logic [LCW-1:0]   load_cnt_q;
  logic [BIW-1:0]   bit_idx_q;
  logic [RES_W-1:0] trial_q;

  assign sh_load  = (state_q == ST_LOAD);
  assign sh_hold  = (state_q == ST_CONV);
  assign dac_code = trial_q;
  assign done     = run && tick && (state_q == ST_CONV) && (bit_idx_q == '0);

  always_comb begin
    result    = trial_q;
    result[0] = cmp_above;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      load_cnt_q <= '0;
      bit_idx_q  <= '0;
      trial_q    <= '0;
    end else if (!run) begin
      state_q    <= ST_IDLE;
      load_cnt_q <= '0;
      bit_idx_q  <= '0;
      trial_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_q    <= ST_LOAD;
          load_cnt_q <= '0;
        end
        ST_LOAD: begin
          if (tick) begin
            if (load_cnt_q == LCW'(LOAD_TICKS - 1)) begin
              state_q   <= ST_CONV;
              bit_idx_q <= BIW'(RES_W - 1);
              trial_q   <= RES_W'(1) << (RES_W - 1);
            end else begin
              load_cnt_q <= load_cnt_q + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (tick) begin
            trial_q[bit_idx_q] <= cmp_above;
            if (bit_idx_q == '0) begin
              state_q    <= ST_LOAD;
              load_cnt_q <= '0;
            end else begin
              bit_idx_q              <= bit_idx_q - 1'b1;
              trial_q[bit_idx_q - 1'b1] <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_exclusive_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh_load && sh_hold));

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sh_load && !sh_hold));

  assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_hold) |-> (dac_code == (RES_W'(1) << (RES_W - 1))));

  assert_step_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_hold && run && !tick) |=> $stable(dac_code));
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int RES_W = 8,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [7:0]       wdata,
  input  logic             done,
  input  logic [RES_W-1:0] result,
  output logic [7:0]       rdata,
  output logic             run,
  output logic [CH_W-1:0]  ch
);
  logic             en_q;
  logic             flag_q;
  logic [CH_W-1:0]  ch_q;
  logic [RES_W-1:0] data_q;
  logic             csr_wr;
  logic             data_rd;
  logic             unused_wbits;

  assign csr_wr       = wr_en && (addr == ADDR_CSR);
  assign data_rd      = rd_en && (addr == ADDR_DATA);
  assign unused_wbits = ^{wdata[7:6], wdata[4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ch_q <= '0;
    end else if (csr_wr) begin
      en_q <= wdata[CSR_EN_BIT];
      ch_q <= wdata[CH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_q <= 1'b0;
    else if (done)               flag_q <= 1'b1;
    else if (csr_wr || data_rd)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (done)  data_q <= result;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CSR) begin
      rdata[CSR_FLAG_BIT] = flag_q;
      rdata[CSR_EN_BIT]   = en_q;
      rdata[CH_W-1:0]     = ch_q;
    end else begin
      rdata = 8'(data_q);
    end
  end

  assign run = en_q;
  assign ch  = ch_q;

  assert_flag_on_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);

  assert_flag_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !done) |=> !flag_q);

  assert_data_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(data_q));
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int DIV        = 4,
  parameter int LOAD_TICKS = 4,
  parameter int RES_W      = 8,
  parameter int CH_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic             reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic [CH_W-1:0]  ch_sel,
  output logic             sh_load,
  output logic             sh_hold,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_above
);
  logic             run;
  logic             tick;
  logic             done;
  logic [RES_W-1:0] result;

  sar_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  sar_core #(.RES_W(RES_W), .LOAD_TICKS(LOAD_TICKS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .cmp_above (cmp_above),
    .sh_load   (sh_load),
    .sh_hold   (sh_hold),
    .dac_code  (dac_code),
    .done      (done),
    .result    (result)
  );

  sar_regs #(.RES_W(RES_W), .CH_W(CH_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .rd_en  (reg_rd_en),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .done   (done),
    .result (result),
    .rdata  (reg_rdata),
    .run    (run),
    .ch     (ch_sel)
  );
endmodule

// File: tb/sar_adc_seq_tb.sv
`timescale 1ns/1ps
module sar_adc_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic       reg_rd_en = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [3:0] ch_sel;
  logic       sh_load;
  logic       sh_hold;
  logic [7:0] dac_code;
  logic       cmp_above;

  int n_tests = 0;
  int n_fail  = 0;
  int vin_live = 0;
  int vin_base = 0;
  int cap = 0;
  bit scramble = 1'b0;

  always #2.5 clk = ~clk;

  sar_adc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_sel(ch_sel), .sh_load(sh_load), .sh_hold(sh_hold),
    .dac_code(dac_code), .cmp_above(cmp_above)
  );

  // behavioural input, hold capacitor and comparator
  assign cmp_above = (cap >= int'(dac_code));

  always @(negedge clk) begin
    if (scramble) begin
      if (sh_hold) vin_live = int'($urandom_range(0, 255));
      else         vin_live = vin_base;
    end
    if (sh_load) cap = vin_live;
  end

  function automatic int clamp8(int v);
    if (v < 0)   return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csr_write(logic [7:0] v);
    reg_addr = 1'b0; reg_wdata = v; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic peek_csr(output logic [7:0] v);
    reg_addr = 1'b0;
    #1 v = reg_rdata;
    @(negedge clk);
  endtask

  task automatic read_data(output logic [7:0] v);
    reg_addr = 1'b1; reg_rd_en = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic wait_flag(output bit ok);
    logic [7:0] c;
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      peek_csr(c);
      if (c[7]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic get_result(output logic [7:0] v, output bit ok);
    wait_flag(ok);
    read_data(v);
  endtask

  task automatic conv_check(int v, string req);
    logic [7:0] r;
    bit ok;
    vin_base = v;
    vin_live = v;
    read_data(r);
    get_result(r, ok);
    get_result(r, ok);
    chk(ok, {req, " flag timeout"}, 0, 1);
    chk(r == 8'(clamp8(v)), req, r, clamp8(v));
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] keep;
    bit ok;
    int cnt;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9 reset state
    peek_csr(r);
    chk(r == 8'h00, "R9 csr", r, 0);
    chk(!sh_load && !sh_hold && ch_sel == 4'h0 && dac_code == 8'h00, "R9 lines", {sh_load, sh_hold}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 1'b1; #1;
    chk(reg_rdata == 8'h00, "R9 data", reg_rdata, 0);
    @(negedge clk);

    // R2 field layout, padding bits ignored
    csr_write(8'h7A);
    peek_csr(r);
    chk(r[6:0] == 7'h2A, "R2 csr readback", r[6:0], 8'h2A);
    chk(ch_sel == 4'hA, "R2 ch_sel", ch_sel, 4'hA);

    // R5 clamps and R4 basic values
    conv_check(300, "R5 top");
    conv_check(-20, "R5 bottom");
    conv_check(255, "R5 full");
    conv_check(0, "R5 zero");
    conv_check(1, "R4 one");
    conv_check(128, "R4 mid");

    // R6 back-to-back results with no register write
    vin_base = 77; vin_live = 77;
    read_data(r);
    get_result(r, ok);
    for (int k = 0; k < 3; k++) begin
      get_result(r, ok);
      chk(ok && r == 8'd77, "R6 continuous", r, 77);
    end

    // R1/R3/R4/R7 timed run with set/clear collision
    vin_base = 100; vin_live = 100;
    get_result(r, ok);
    read_data(r);
    while (sh_hold) @(negedge clk);
    while (!sh_hold) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 31; i++) begin
      if (sh_hold && !sh_load) cnt++;
      if (i == 0) chk(dac_code == 8'h80, "R4 first trial", dac_code, 8'h80);
      if (i == 4) chk(dac_code == 8'h40, "R4 second trial", dac_code, 8'h40);
      @(negedge clk);
    end
    chk(cnt == 31 && sh_hold, "R1 hold width", cnt, 31);
    reg_addr = 1'b1; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    chk(!sh_hold && sh_load, "R1 hold ends at 32", sh_hold, 0);
    reg_addr = 1'b0; #1;
    chk(reg_rdata[7] == 1'b1, "R7 set wins over read", reg_rdata[7], 1);
    @(negedge clk);
    cnt = 1;
    while (sh_load && cnt < 100) begin cnt++; @(negedge clk); end
    chk(cnt == 16 && sh_hold, "R3 load width", cnt, 16);
    read_data(r);
    chk(r == 8'd100, "R7 fresh data", r, 100);
    peek_csr(r);
    chk(r[7] == 1'b0, "R7 data read clears", r[7], 0);

    // R7 CSR write clears the flag
    wait_flag(ok);
    csr_write(8'h2A);
    peek_csr(r);
    chk(r[7] == 1'b0, "R7 csr write clears", r[7], 0);

    // R3 input scrambled during hold must not matter (random sweep)
    for (int k = 0; k < 24; k++) begin
      int v;
      v = int'($urandom_range(0, 330)) - 30;
      scramble = (k % 2 == 1);
      conv_check(v, scramble ? "R3 hold random" : "R4 random");
    end
    scramble = 1'b0;

    // R8 abort mid-conversion
    vin_base = 200; vin_live = 200;
    get_result(keep, ok);
    get_result(keep, ok);
    while (!sh_hold) @(negedge clk);
    repeat (5) @(negedge clk);
    csr_write(8'h0A);
    @(negedge clk);
    chk(!sh_hold && !sh_load, "R8 lines released", {sh_hold, sh_load}, 0);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      if (sh_hold || sh_load) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R8 stays idle", cnt, 0);
    peek_csr(r);
    chk(r[7] == 1'b0, "R8 no completion", r[7], 0);
    read_data(r);
    chk(r == keep, "R8 data kept", r, keep);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule